// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block keeps the running position of a DMA channel that walks memory in a one- or two-dimensional pattern. A load pulse hands it a start address, an element count per row, a row count, two signed 16-bit step sizes and a few configuration flags. From then on, each element-done pulse from the data mover advances the current address by the element step and counts the element off the current row.

When a row is used up, the block acts on the configuration. In 2D mode with rows still to go, it wraps to the next row. It applies the row step in place of the last element step and refills the element count. Otherwise the pattern is finished. In stop flow it parks in a done state. In any other flow it asks for the next descriptor and waits for a new load. If enabled, an interrupt pulse marks the end of every row.

The controller has four states:
- IDLE: after reset.
- RUN: elements are being counted.
- DONE: a stop-flow pattern has finished.
- WAIT_DESC: a descriptor reload has been requested.

Transitions:
- load: any state to RUN.
- row-wrap: RUN to RUN.
- finish-stop: RUN to DONE.
- finish-chain: RUN to WAIT_DESC.

Top module: `dma_addr_gen`

## Requirements
- R1: A load pulse, accepted in any state, copies the start address and both counts into the current registers. It sets `running` and clears `done` on the following clock edge.
- R2: In RUN, each element-done pulse adds the sign-extended X step to the address and decrements the element count, both visible one clock after the pulse.
- R3: When the element count reaches its last element and `cfg_irq_en` is 1, `irq` is high for exactly one cycle, the cycle after that pulse. With `cfg_irq_en` at 0, `irq` stays low.
- R4: In 2D mode (`cfg_2d`=1), the last element of a row with a row count above 1 works as follows. The row count drops by one and the element count is refilled from its loaded value. The address becomes the address before that element plus the sign-extended Y step.
- R5: When the last element does not wrap and `cfg_flow` is 2'b00 (stop), the block enters DONE: `running` goes low and `done` goes high.
- R6: When the last element does not wrap and `cfg_flow` is nonzero, `reload_req` is high for exactly one cycle. The block waits with both `running` and `done` low.
- R7: Element-done pulses while not in RUN change neither the address, the counts, nor the state.
- R8: A loaded count of zero is taken as 16'hFFFF, for both the element and the row count.
- R9: The address is 32 bits and wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Start a new pattern with the load values |
| load_addr | input | 32 | Start address |
| load_xcnt | input | 16 | Elements per row (0 means 65535) |
| load_ycnt | input | 16 | Rows (0 means 65535) |
| load_xmod | input | 16 | Signed element step |
| load_ymod | input | 16 | Signed row step |
| cfg_2d | input | 1 | Two-dimensional mode |
| cfg_irq_en | input | 1 | Row-end interrupt enable |
| cfg_flow | input | 2 | 00 stop, other values chain to next descriptor |
| elem_done | input | 1 | One element transferred |
| cur_addr | output | 32 | Current address |
| cur_xcnt | output | 16 | Elements left in row |
| cur_ycnt | output | 16 | Rows left |
| running | output | 1 | In RUN state |
| done | output | 1 | In DONE state |
| irq | output | 1 | Row-end interrupt pulse |
| reload_req | output | 1 | Next-descriptor request pulse |

## Verification
The stepping path is tried with several step patterns:
- Positive and negative element steps tell sign extension apart from zero extension.
- A start near the top of memory shows the 32-bit wrap.
- 2D runs with positive and negative row steps show whether the row step replaces the last element step or is added to it.

Runs are stopped part-way and at the end to separate mid-row counting from the stop and chain outcomes. Zero counts show the 65535 substitution. The pulse outputs and the ignored element pulses are checked cycle by cycle in directed tests.

// File: rtl/dag_pkg.sv
package dag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE,
        ST_WAIT_DESC
    } dag_state_e;

    localparam logic [1:0] FLOW_STOP = 2'b00;
endpackage

// File: rtl/dag_count.sv
module dag_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         reload,
    input  logic         dec,
    output logic [W-1:0] q,
    output logic         is_one,
    output logic         gt_one
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] prog_r;
    logic [W-1:0] eff_val;

    // zero count stands for the largest count (R8)
    assign eff_val = (load_val == '0) ? '1 : load_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            prog_r <= '0;
        end else if (load) begin
            q      <= eff_val;
            prog_r <= eff_val;
        end else if (reload) begin
            q      <= prog_r;
        end else if (dec) begin
            q      <= q - ONE;
        end
    end

    assign is_one = (q == ONE);
    assign gt_one = (q > ONE);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !reload) |=> (q == W'($past(q) - ONE)));

    assert_zero_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> (q == '1));
endmodule

// File: rtl/dag_addr.sv
module dag_addr #(
    parameter int AW = 32,
    parameter int MW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic [MW-1:0] load_xmod,
    input  logic [MW-1:0] load_ymod,
    input  logic          step_x,
    input  logic          step_y,
    output logic [AW-1:0] addr
);
    localparam int EXT = AW - MW;

    logic [MW-1:0] xmod_r;
    logic [MW-1:0] ymod_r;
    logic [AW-1:0] xext;
    logic [AW-1:0] yext;

    assign xext = {{EXT{xmod_r[MW-1]}}, xmod_r};
    assign yext = {{EXT{ymod_r[MW-1]}}, ymod_r};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr   <= '0;
            xmod_r <= '0;
            ymod_r <= '0;
        end else if (load) begin
            addr   <= load_val;
            xmod_r <= load_xmod;
            ymod_r <= load_ymod;
        end else if (step_y) begin
            // row step replaces the last element step (R4)
            addr   <= addr + yext;
        end else if (step_x) begin
            addr   <= addr + xext;
        end
    end

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_x && !step_y && !load) |=> (addr == $past(addr) + xext));

    assert_addr_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_x && step_y));
endmodule

// File: rtl/dag_ctrl.sv
module dag_ctrl
    import dag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       cfg_2d,
    input  logic       cfg_irq_en,
    input  logic [1:0] cfg_flow,
    input  logic       elem_done,
    input  logic       x_is_one,
    input  logic       y_gt_one,
    output logic       x_dec,
    output logic       x_reload,
    output logic       y_dec,
    output logic       step_x,
    output logic       step_y,
    output logic       irq,
    output logic       reload_req,
    output dag_state_e state
);
    logic       two_d_r;
    logic       irq_en_r;
    logic [1:0] flow_r;
    logic       fire;
    logic       row_end;
    logic       wrap;
    logic       finish;
    dag_state_e state_nx;

    assign fire    = (state == ST_RUN) && elem_done && !load;
    assign row_end = fire && x_is_one;
    assign wrap    = row_end && two_d_r && y_gt_one;
    assign finish  = row_end && !wrap;

    assign x_dec    = fire && !wrap;
    assign step_x   = fire && !wrap;
    assign x_reload = wrap;
    assign y_dec    = wrap;
    assign step_y   = wrap;

    always_comb begin
        state_nx = state;
        if (load) begin
            state_nx = ST_RUN;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_RUN: begin
                    if (finish)
                        state_nx = (flow_r == FLOW_STOP) ? ST_DONE : ST_WAIT_DESC;
                end
                ST_DONE:      state_nx = ST_DONE;
                ST_WAIT_DESC: state_nx = ST_WAIT_DESC;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            two_d_r  <= 1'b0;
            irq_en_r <= 1'b0;
            flow_r   <= FLOW_STOP;
        end else begin
            state <= state_nx;
            if (load) begin
                two_d_r  <= cfg_2d;
                irq_en_r <= cfg_irq_en;
                flow_r   <= cfg_flow;
            end
        end
    end

    // registered pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            reload_req <= 1'b0;
        end else begin
            irq        <= row_end && irq_en_r;
            reload_req <= finish && (flow_r != FLOW_STOP);
        end
    end

    assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(elem_done));

    assert_reload_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |=> !reload_req);

    assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !load) |=> (state == ST_DONE));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dag_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_xcnt,
    input  logic [CW-1:0] load_ycnt,
    input  logic [CW-1:0] load_xmod,
    input  logic [CW-1:0] load_ymod,
    input  logic          cfg_2d,
    input  logic          cfg_irq_en,
    input  logic [1:0]    cfg_flow,
    input  logic          elem_done,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_xcnt,
    output logic [CW-1:0] cur_ycnt,
    output logic          running,
    output logic          done,
    output logic          irq,
    output logic          reload_req
);
    logic       x_dec, x_reload, y_dec, step_x, step_y;
    logic       x_is_one, x_gt_one, y_is_one, y_gt_one;
    dag_state_e state;

    dag_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .cfg_2d     (cfg_2d),
        .cfg_irq_en (cfg_irq_en),
        .cfg_flow   (cfg_flow),
        .elem_done  (elem_done),
        .x_is_one   (x_is_one),
        .y_gt_one   (y_gt_one),
        .x_dec      (x_dec),
        .x_reload   (x_reload),
        .y_dec      (y_dec),
        .step_x     (step_x),
        .step_y     (step_y),
        .irq        (irq),
        .reload_req (reload_req),
        .state      (state)
    );

    dag_count #(.W(CW)) u_xcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_xcnt),
        .reload   (x_reload),
        .dec      (x_dec),
        .q        (cur_xcnt),
        .is_one   (x_is_one),
        .gt_one   (x_gt_one)
    );

    dag_count #(.W(CW)) u_ycnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_ycnt),
        .reload   (1'b0),
        .dec      (y_dec),
        .q        (cur_ycnt),
        .is_one   (y_is_one),
        .gt_one   (y_gt_one)
    );

    dag_addr #(.AW(AW), .MW(CW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (load_addr),
        .load_xmod (load_xmod),
        .load_ymod (load_ymod),
        .step_x    (step_x),
        .step_y    (step_y),
        .addr      (cur_addr)
    );

    assign running = (state == ST_RUN);
    assign done    = (state == ST_DONE);

    assert_load_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (running && !done && cur_addr == $past(load_addr)));

    assert_idle_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load) |=> ($stable(cur_addr) && $stable(cur_xcnt) && $stable(cur_ycnt)));

    assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(running && done));
endmodule

// File: tb/sim_dma_addr_gen.sv
`timescale 1ns/1ps
module sim_dma_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [31:0] load_addr = '0;
    logic [15:0] load_xcnt = '0, load_ycnt = '0, load_xmod = '0, load_ymod = '0;
    logic        cfg_2d = 1'b0, cfg_irq_en = 1'b0;
    logic [1:0]  cfg_flow = 2'b00;
    logic        elem_done = 1'b0;
    logic [31:0] cur_addr;
    logic [15:0] cur_xcnt, cur_ycnt;
    logic        running, done, irq, reload_req;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dma_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
        .load_xcnt(load_xcnt), .load_ycnt(load_ycnt), .load_xmod(load_xmod),
        .load_ymod(load_ymod), .cfg_2d(cfg_2d), .cfg_irq_en(cfg_irq_en),
        .cfg_flow(cfg_flow), .elem_done(elem_done), .cur_addr(cur_addr),
        .cur_xcnt(cur_xcnt), .cur_ycnt(cur_ycnt), .running(running),
        .done(done), .irq(irq), .reload_req(reload_req)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] xc;
        logic [15:0] yc;
        logic [15:0] xm;
        logic [15:0] ym;
        logic        two_d;
        logic [1:0]  flow;
        logic [7:0]  n;
        logic [31:0] e_addr;
        logic [15:0] e_x;
        logic [15:0] e_y;
        logic        e_run;
        logic        e_done;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [0:NV-1] = '{
        // R2 mid-row
        '{32'h0000_1000, 16'd4, 16'd1, 16'h0004, 16'h0000, 1'b0, 2'b00, 8'd2, 32'h0000_1008, 16'd2, 16'd1, 1'b1, 1'b0},
        // R5 stop at end
        '{32'h0000_1000, 16'd4, 16'd1, 16'h0004, 16'h0000, 1'b0, 2'b00, 8'd4, 32'h0000_1010, 16'd0, 16'd1, 1'b0, 1'b1},
        // R4 row wrap
        '{32'h0000_2000, 16'd3, 16'd2, 16'h0002, 16'h0010, 1'b1, 2'b00, 8'd3, 32'h0000_2014, 16'd3, 16'd1, 1'b1, 1'b0},
        // R4 R5 last row then stop
        '{32'h0000_2000, 16'd3, 16'd2, 16'h0002, 16'h0010, 1'b1, 2'b00, 8'd6, 32'h0000_201A, 16'd0, 16'd1, 1'b0, 1'b1},
        // R2 negative step
        '{32'h0000_0100, 16'd2, 16'd1, 16'hFFFC, 16'h0000, 1'b0, 2'b00, 8'd1, 32'h0000_00FC, 16'd1, 16'd1, 1'b1, 1'b0},
        // R9 address wrap
        '{32'hFFFF_FFFE, 16'd5, 16'd1, 16'h0004, 16'h0000, 1'b0, 2'b00, 8'd1, 32'h0000_0002, 16'd4, 16'd1, 1'b1, 1'b0},
        // R8 zero counts
        '{32'h0000_0000, 16'd0, 16'd0, 16'h0001, 16'h0000, 1'b0, 2'b00, 8'd1, 32'h0000_0001, 16'hFFFE, 16'hFFFF, 1'b1, 1'b0},
        // R6 chain flow at end
        '{32'h0000_0050, 16'd2, 16'd1, 16'h0001, 16'h0000, 1'b0, 2'b01, 8'd2, 32'h0000_0052, 16'd0, 16'd1, 1'b0, 1'b0},
        // R4 negative row step
        '{32'h0000_0400, 16'd2, 16'd3, 16'h0008, 16'hFFE0, 1'b1, 2'b00, 8'd2, 32'h0000_03E8, 16'd2, 16'd2, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] a, input logic [15:0] xc, input logic [15:0] yc,
                           input logic [15:0] xm, input logic [15:0] ym, input logic td,
                           input logic ie, input logic [1:0] fl);
        @(negedge clk);
        load = 1'b1; load_addr = a; load_xcnt = xc; load_ycnt = yc;
        load_xmod = xm; load_ymod = ym; cfg_2d = td; cfg_irq_en = ie; cfg_flow = fl;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic elem();
        @(negedge clk);
        elem_done = 1'b1;
        @(negedge clk);
        elem_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1 reset addr", cur_addr, 32'h0);
        chk("R1 reset running", {31'b0, running}, 32'h0);
        chk("R5 reset done", {31'b0, done}, 32'h0);
        chk("R3 reset irq", {31'b0, irq}, 32'h0);

        // R7 element pulse while idle
        elem();
        chk("R7 idle addr", cur_addr, 32'h0);
        chk("R7 idle running", {31'b0, running}, 32'h0);

        // table: R1 R2 R4 R5 R6 R8 R9
        for (int i = 0; i < NV; i++) begin
            do_load(VECS[i].addr, VECS[i].xc, VECS[i].yc, VECS[i].xm, VECS[i].ym,
                    VECS[i].two_d, 1'b0, VECS[i].flow);
            for (int k = 0; k < int'(VECS[i].n); k++) elem();
            chk($sformatf("R2 R4 R9 vec%0d addr", i), cur_addr, VECS[i].e_addr);
            chk($sformatf("R2 R4 R8 vec%0d xcnt", i), {16'h0, cur_xcnt}, {16'h0, VECS[i].e_x});
            chk($sformatf("R4 R8 vec%0d ycnt", i), {16'h0, cur_ycnt}, {16'h0, VECS[i].e_y});
            chk($sformatf("R1 R6 vec%0d running", i), {31'b0, running}, {31'b0, VECS[i].e_run});
            chk($sformatf("R5 R6 vec%0d done", i), {31'b0, done}, {31'b0, VECS[i].e_done});
        end

        // R1 load right after values: check immediate loaded state
        do_load(32'h0000_3000, 16'd0, 16'd7, 16'h0001, 16'h0000, 1'b0, 1'b1, 2'b00);
        chk("R1 load addr", cur_addr, 32'h0000_3000);
        chk("R8 load xcnt zero", {16'h0, cur_xcnt}, 32'h0000_FFFF);
        chk("R1 load ycnt", {16'h0, cur_ycnt}, 32'd7);
        chk("R1 load running", {31'b0, running}, 32'h1);

        // R3 interrupt pulse with enable
        do_load(32'h0000_0000, 16'd2, 16'd1, 16'h0001, 16'h0000, 1'b0, 1'b1, 2'b00);
        elem();
        chk("R3 no irq mid-row", {31'b0, irq}, 32'h0);
        elem();
        chk("R3 irq at row end", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R3 irq one cycle", {31'b0, irq}, 32'h0);
        // R7 pulse while done
        elem();
        chk("R7 done addr", cur_addr, 32'h0000_0002);
        chk("R7 done state", {31'b0, done}, 32'h1);

        // R3 irq per row in 2D
        do_load(32'h0000_0000, 16'd1, 16'd2, 16'h0001, 16'h0004, 1'b1, 1'b1, 2'b00);
        elem();
        chk("R3 R4 irq on wrap", {31'b0, irq}, 32'h1);
        chk("R4 wrap addr", cur_addr, 32'h0000_0004);

        // R3 no irq when disabled
        do_load(32'h0000_0000, 16'd1, 16'd1, 16'h0001, 16'h0000, 1'b0, 1'b0, 2'b00);
        elem();
        chk("R3 irq disabled", {31'b0, irq}, 32'h0);
        chk("R5 done after one", {31'b0, done}, 32'h1);

        // R6 reload request pulse
        do_load(32'h0000_0010, 16'd1, 16'd1, 16'h0002, 16'h0000, 1'b0, 1'b0, 2'b10);
        elem();
        chk("R6 reload pulse", {31'b0, reload_req}, 32'h1);
        chk("R6 waiting not done", {31'b0, done}, 32'h0);
        chk("R6 waiting not running", {31'b0, running}, 32'h0);
        @(negedge clk);
        chk("R6 reload one cycle", {31'b0, reload_req}, 32'h0);
        // R7 pulse while waiting
        elem();
        chk("R7 wait addr", cur_addr, 32'h0000_0012);
        chk("R7 wait xcnt", {16'h0, cur_xcnt}, 32'h0);
        chk("R7 wait no reload", {31'b0, reload_req}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule